// File: doc/BRIEF.md
# Oversampling Clock-Recovery Line Decoder

This block recovers bit timing and data from a single-wire serial receive line. It runs on a sampling clock that is 1, 8, 16 or 32 times the bit rate. A digital phase tracker restarts its count on every line transition and samples near the middle of each symbol. A symbol is a whole bit for the level-coded formats and a half bit for the two-level (biphase) formats. A decoder then turns the samples into data bits for one of five line codes. An invert control selects the complementary variant of a code.

The input source is either the external receive pin or, in local loopback, the output of a nearby transmitter. The block reports each decoded bit with a valid strobe. It also gives a one-cycle recovered-clock enable for every accepted bit period. A configuration-error flag marks any rate and code pair that is reserved or not allowed. A code-violation pulse marks a broken symbol once the decoder has locked. No bit is reported before the decoder has seen eight clean bit periods in a row.

Top module: `line_dpll_dec`

## Requirements
- R1: `rate_sel` sets the oversampling factor N: 00 gives 1, 01 gives 8, 10 gives 16 and 11 gives 32. On a line with no transitions, `bclk_en` pulses exactly once every N clocks.
- R2: `code_sel` chooses the line code: 000 NRZ, 001 NRZI, 010 FM, 100 Manchester, 110 differential Manchester. The values 011, 101 and 111 are reserved and raise `cfg_err` at every rate.
- R3: At rate 00 only NRZ and NRZI are legal. FM, Manchester and differential Manchester at rate 00 raise `cfg_err`. Every non-reserved code is legal at the other rates.
- R4: While `cfg_err` is high, the block produces no `bclk_en`, no `bit_vld` and no `cv_err`.
- R5: NRZ: the decoded bit is the sampled line level XOR `rx_inv`.
- R6: NRZI: with `rx_inv`=0 a level change across a bit decodes as 1 and no change as 0 (mark). With `rx_inv`=1 the meaning is swapped (space).
- R7: FM: the level always changes at each bit boundary. With `rx_inv`=0 a bit with no mid-bit change decodes as 1 and a bit with a mid-bit change as 0. With `rx_inv`=1 the meaning is swapped.
- R8: Manchester: with `rx_inv`=0 a high-to-low change at mid-bit decodes as 1 and low-to-high as 0. `rx_inv`=1 inverts the line polarity.
- R9: Differential Manchester: a level change at the bit boundary decodes as 0 and no change as 1. `rx_inv` has no effect.
- R10: The phase tracker restarts on every line transition, so bits that are occasionally one sampling clock longer than nominal still decode correctly.
- R11: Reset and any configuration change clear lock. The first eight accepted bit periods pulse `bclk_en` without `bit_vld`. The ninth and later ones also raise `bit_vld`.
- R12: Once locked, a symbol that breaks the selected code pulses `cv_err`. For FM this is a missing boundary change; for the Manchester codes it is a missing mid-bit change. Such a symbol also restarts lock.
- R13: With `loop_en`=1 the decoder reads `tx_loop`, and activity on `rx_pin` has no effect on the decoded bits. With `loop_en`=0 it reads `rx_pin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | External serial receive line |
| tx_loop | input | 1 | Local transmitter output used in loopback |
| loop_en | input | 1 | 1 selects `tx_loop` as the decoder input |
| rate_sel | input | 2 | Oversampling factor select |
| code_sel | input | 3 | Line code select |
| rx_inv | input | 1 | Selects the complementary code variant |
| bit_out | output | 1 | Last decoded data bit |
| bit_vld | output | 1 | `bit_out` holds a new bit this cycle |
| bclk_en | output | 1 | One pulse per accepted bit period |
| cfg_err | output | 1 | Reserved or illegal rate and code pair |
| cv_err | output | 1 | Code violation seen while locked |

## Verification
If the phase counter drifts or half-bit pairing goes wrong, the effect shows within one or two bit periods. For the biphase codes, a wrong pairing shows up as slips, so the decoded stream loses or repeats bits and the sent pattern cannot be found in the `bit_vld` stream. A wrong count in the phase counter changes the spacing of `bclk_en` on an idle line at once. A lock counter that clears or saturates at the wrong value moves the first `bit_vld` away from the ninth `bclk_en` pulse. A fault in the pairing of half-bit symbols makes `cv_err` pulse during a clean stream or stay low after a deliberately removed boundary transition.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int PER_W = 6;

    typedef enum logic [1:0] {
        OVS_X1  = 2'b00,
        OVS_X8  = 2'b01,
        OVS_X16 = 2'b10,
        OVS_X32 = 2'b11
    } ovs_e;

    typedef enum logic [2:0] {
        LC_NRZ  = 3'b000,
        LC_NRZI = 3'b001,
        LC_FM   = 3'b010,
        LC_RSV3 = 3'b011,
        LC_MAN  = 3'b100,
        LC_RSV5 = 3'b101,
        LC_DMAN = 3'b110,
        LC_RSV7 = 3'b111
    } lcode_e;

    typedef struct packed {
        ovs_e   rate;
        lcode_e code;
        logic   inv;
    } dcfg_t;

    function automatic logic [PER_W-1:0] ovs_ratio(input ovs_e r);
        case (r)
            OVS_X1:  return PER_W'(1);
            OVS_X8:  return PER_W'(8);
            OVS_X16: return PER_W'(16);
            default: return PER_W'(32);
        endcase
    endfunction

    function automatic logic is_biphase(input lcode_e c);
        return (c == LC_FM) || (c == LC_MAN) || (c == LC_DMAN);
    endfunction

    function automatic logic cfg_legal(input ovs_e r, input lcode_e c);
        case (c)
            LC_NRZ, LC_NRZI:       return 1'b1;
            LC_FM, LC_MAN, LC_DMAN: return r != OVS_X1;
            default:               return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dpll_phase.sv
module dpll_phase
    import dpll_pkg::*;
#(
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          line,
    input  logic [PW-1:0] period,
    output logic          smp,
    output logic          stb
);

    logic          ln_q;
    logic          ln_p;
    logic [PW-1:0] cnt;
    logic [PW-1:0] base;
    logic [PW-1:0] cnt_nxt;

    // a transition re-centres the count: the sample holding the new level is phase 0
    always_comb begin
        base    = (ln_q != ln_p) ? '0 : cnt;
        cnt_nxt = (base >= period - 1'b1) ? '0 : base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q <= 1'b0;
            ln_p <= 1'b0;
            cnt  <= '0;
        end else begin
            ln_q <= line;
            ln_p <= ln_q;
            cnt  <= restart ? '0 : cnt_nxt;
        end
    end

    assign smp = ln_q;
    assign stb = (cnt == (period >> 1));

    // R10
    stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && period > PW'(1)) |=> (!stb || period == PW'(1)));

endmodule

// File: rtl/dpll_symdec.sv
module dpll_symdec
    import dpll_pkg::*;
#(
    parameter int LOCK_BITS = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   stb,
    input  logic   smp,
    input  lcode_e code,
    input  logic   inv,
    output logic   bit_out,
    output logic   bit_vld,
    output logic   bclk_en,
    output logic   cv_err
);

    localparam int LW = $clog2(LOCK_BITS + 1);
    localparam logic [LW-1:0] LOCK_MAX = LW'(LOCK_BITS);

    logic          second;
    logic          first_h;
    logic          prev_h;
    logic          prev_s;
    logic [LW-1:0] lock_cnt;
    logic          biph;
    logic          done;
    logic          ok;
    logic          bitv;
    logic          locked;

    assign biph   = is_biphase(code);
    assign done   = stb && (!biph || second);
    assign locked = (lock_cnt == LOCK_MAX);

    always_comb begin
        ok   = 1'b1;
        bitv = 1'b0;
        case (code)
            LC_NRZ:  bitv = smp ^ inv;
            LC_NRZI: bitv = (smp ^ prev_s) ^ inv;
            LC_FM: begin
                ok   = (first_h != prev_h);
                bitv = (first_h == smp) ^ inv;
            end
            LC_MAN: begin
                ok   = (first_h != smp);
                bitv = first_h ^ inv;
            end
            LC_DMAN: begin
                ok   = (first_h != smp);
                bitv = (first_h == prev_h);
            end
            default: ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            second   <= 1'b0;
            first_h  <= 1'b0;
            prev_h   <= 1'b0;
            prev_s   <= 1'b0;
            lock_cnt <= '0;
            bit_out  <= 1'b0;
            bit_vld  <= 1'b0;
            bclk_en  <= 1'b0;
            cv_err   <= 1'b0;
        end else begin
            bclk_en <= done && ok;
            bit_vld <= done && ok && locked;
            cv_err  <= done && !ok && locked;
            if (done && ok) bit_out <= bitv;
            if (stb) prev_s <= smp;
            if (stb && biph) begin
                if (!second) begin
                    first_h <= smp;
                    second  <= 1'b1;
                end else if (ok) begin
                    prev_h <= smp;
                    second <= 1'b0;
                end else begin
                    // slip by one half: current sample opens the next pair
                    first_h <= smp;
                    prev_h  <= first_h;
                end
            end
            if (done) begin
                if (!ok)          lock_cnt <= '0;
                else if (!locked) lock_cnt <= lock_cnt + 1'b1;
            end
        end
    end

    // R11
    vld_has_clk_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> bclk_en);

    // R12
    cv_excl_chk: assert property (@(posedge clk) disable iff (rst)
        cv_err |-> (!bclk_en && !bit_vld));

    // R11
    lock_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> !bit_vld);

endmodule

// File: rtl/line_dpll_dec.sv
module line_dpll_dec
    import dpll_pkg::*;
#(
    parameter int LOCK_BITS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_pin,
    input  logic       tx_loop,
    input  logic       loop_en,
    input  logic [1:0] rate_sel,
    input  logic [2:0] code_sel,
    input  logic       rx_inv,
    output logic       bit_out,
    output logic       bit_vld,
    output logic       bclk_en,
    output logic       cfg_err,
    output logic       cv_err
);

    dcfg_t             cfg_now;
    dcfg_t             cfg_q;
    logic              restart;
    logic              line;
    logic [PER_W-1:0]  ratio;
    logic [PER_W-1:0]  period;
    logic              smp;
    logic              stb;

    assign cfg_now = '{rate: ovs_e'(rate_sel), code: lcode_e'(code_sel), inv: rx_inv};

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '{rate: OVS_X1, code: LC_NRZ, inv: 1'b0};
        else     cfg_q <= cfg_now;
    end

    assign cfg_err = !cfg_legal(cfg_now.rate, cfg_now.code);
    assign restart = cfg_err || (cfg_now != cfg_q);
    assign line    = loop_en ? tx_loop : rx_pin;
    assign ratio   = ovs_ratio(cfg_now.rate);
    assign period  = is_biphase(cfg_now.code) ? (ratio >> 1) : ratio;

    dpll_phase #(.PW(PER_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .line    (line),
        .period  (period),
        .smp     (smp),
        .stb     (stb)
    );

    dpll_symdec #(.LOCK_BITS(LOCK_BITS)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .stb     (stb),
        .smp     (smp),
        .code    (cfg_now.code),
        .inv     (cfg_now.inv),
        .bit_out (bit_out),
        .bit_vld (bit_vld),
        .bclk_en (bclk_en),
        .cv_err  (cv_err)
    );

    // R4
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> (!bclk_en && !bit_vld && !cv_err));

endmodule

// File: tb/test_line_dpll_dec.sv
module test_line_dpll_dec;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;
    localparam int PRE_BITS   = 24;
    localparam int NV         = 11;

    typedef struct packed {
        logic [1:0]  rate;
        logic [2:0]  code;
        logic        inv;
        logic        skew;
        logic [1:0]  pre;
        logic [15:0] data;
    } vec_t;

    // pre: 0 all zeros, 1 all ones, 2 alternating
    localparam vec_t VECS [NV] = '{
        '{2'b00, 3'b000, 1'b0, 1'b0, 2'd2, 16'hB38E},
        '{2'b00, 3'b000, 1'b1, 1'b0, 2'd2, 16'h5C3A},
        '{2'b00, 3'b001, 1'b0, 1'b0, 2'd0, 16'hB38E},
        '{2'b01, 3'b001, 1'b1, 1'b0, 2'd2, 16'h9E61},
        '{2'b10, 3'b010, 1'b0, 1'b1, 2'd1, 16'hB38E},
        '{2'b11, 3'b010, 1'b1, 1'b0, 2'd0, 16'h4DC6},
        '{2'b01, 3'b100, 1'b0, 1'b0, 2'd2, 16'hB38E},
        '{2'b10, 3'b100, 1'b1, 1'b1, 2'd2, 16'h7163},
        '{2'b11, 3'b110, 1'b0, 1'b0, 2'd1, 16'hB38E},
        '{2'b01, 3'b110, 1'b1, 1'b1, 2'd1, 16'hC5A3},
        '{2'b10, 3'b000, 1'b0, 1'b1, 2'd2, 16'h39D4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_pin = 1'b0;
    logic       tx_loop = 1'b0;
    logic       loop_en = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic [2:0] code_sel = 3'b000;
    logic       rx_inv = 1'b0;
    logic       bit_out, bit_vld, bclk_en, cfg_err, cv_err;

    int   n_chk = 0;
    int   n_bad = 0;
    int   n_got = 0;
    int   n_bclk = 0;
    int   n_pre = 0;
    int   n_cv = 0;
    logic got [256];
    logic lvl = 1'b0;
    logic use_loop = 1'b0;
    logic noisy = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_dpll_dec i_line_dpll_dec (
        .clk(clk), .rst(rst), .rx_pin(rx_pin), .tx_loop(tx_loop),
        .loop_en(loop_en), .rate_sel(rate_sel), .code_sel(code_sel),
        .rx_inv(rx_inv), .bit_out(bit_out), .bit_vld(bit_vld),
        .bclk_en(bclk_en), .cfg_err(cfg_err), .cv_err(cv_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (bclk_en) n_bclk++;
            if (bclk_en && !bit_vld && n_got == 0) n_pre++;
            if (bit_vld) begin
                if (n_got < 256) got[n_got] = bit_out;
                n_got++;
            end
            if (cv_err) n_cv++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
        summary();
        $finish;
    end

    function automatic int ratio_of(input logic [1:0] r);
        return (r == 2'b00) ? 1 : (8 << (r - 2'b01));
    endfunction

    function automatic string tag_of(input vec_t v);
        string s;
        case (v.code)
            3'b000:  s = "R5";
            3'b001:  s = "R6";
            3'b010:  s = "R7";
            3'b100:  s = "R8";
            default: s = "R9";
        endcase
        if (v.skew) s = {s, "/R10"};
        return s;
    endfunction

    task automatic put_level(input logic v, input int dur);
        if (use_loop) tx_loop = v;
        else          rx_pin  = v;
        repeat (dur) begin
            @(negedge clk);
            if (noisy) begin
                if (use_loop) rx_pin  = ~rx_pin;
                else          tx_loop = ~tx_loop;
            end
        end
    endtask

    task automatic send_bit(input logic b, input int n, input logic [2:0] code,
                            input logic inv, input int extra);
        logic h1, h2;
        case (code)
            3'b000: begin lvl = b ^ inv; put_level(lvl, n + extra); end
            3'b001: begin
                if (b ^ inv) lvl = ~lvl;
                put_level(lvl, n + extra);
            end
            3'b010: begin
                h1 = ~lvl;
                h2 = (b ^ inv) ? h1 : ~h1;
                put_level(h1, n/2 + extra);
                put_level(h2, n/2);
                lvl = h2;
            end
            3'b100: begin
                h1 = b ^ inv;
                h2 = ~h1;
                put_level(h1, n/2 + extra);
                put_level(h2, n/2);
                lvl = h2;
            end
            default: begin
                h1 = b ? lvl : ~lvl;
                h2 = ~h1;
                put_level(h1, n/2 + extra);
                put_level(h2, n/2);
                lvl = h2;
            end
        endcase
    endtask

    task automatic start(input logic [1:0] r, input logic [2:0] c, input logic inv,
                         input logic via_loop);
        @(negedge clk);
        rst = 1'b1;
        rate_sel = r; code_sel = c; rx_inv = inv;
        loop_en = via_loop; use_loop = via_loop; noisy = 1'b1;
        lvl = 1'b0; rx_pin = 1'b0; tx_loop = 1'b0;
        repeat (2) @(negedge clk);
        n_got = 0; n_bclk = 0; n_pre = 0; n_cv = 0;
        rst = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input logic via_loop, input string tag);
        int n;
        int found;
        n = ratio_of(v.rate);
        start(v.rate, v.code, v.inv, via_loop);
        for (int i = 0; i < PRE_BITS; i++)
            send_bit((v.pre == 2'd2) ? i[0] : v.pre[0], n, v.code, v.inv, 0);
        n_cv = 0;
        for (int i = 0; i < 16; i++)
            send_bit(v.data[15-i], n, v.code, v.inv, (v.skew && (i % 4 == 1)) ? 1 : 0);
        for (int i = 0; i < 8; i++)
            send_bit((v.pre == 2'd2) ? i[0] : v.pre[0], n, v.code, v.inv, 0);
        found = 0;
        for (int s = 0; s + 16 <= n_got && s + 16 <= 256; s++) begin
            int m;
            m = 1;
            for (int j = 0; j < 16; j++)
                if (got[s+j] !== v.data[15-j]) m = 0;
            if (m == 1) found = 1;
        end
        chk({tag, " pattern found"}, found, 1);
        if (v.code[2] || v.code[1]) chk({tag, "/R12 clean stream cv_err"}, n_cv, 0);
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk("R11 reset bit_vld", int'(bit_vld), 0);
        chk("R11 reset bclk_en", int'(bclk_en), 0);
        chk("R12 reset cv_err", int'(cv_err), 0);
        chk("R3 reset cfg_err", int'(cfg_err), 0);

        // vector walk over codes, rates and polarities
        for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0, tag_of(VECS[k]));

        // R13 loopback path carries the data
        run_vec(VECS[6], 1'b1, "R13 loopback");

        // R13 pin ignored in loopback
        start(2'b00, 3'b000, 1'b0, 1'b1);
        put_level(1'b1, 60);
        begin
            int zeros;
            zeros = 0;
            for (int i = 0; i < n_got && i < 256; i++) if (got[i] !== 1'b1) zeros++;
            chk("R13 pin ignored zeros", zeros, 0);
            chk("R13 bits seen", int'(n_got > 30), 1);
        end

        // R1 bclk spacing per rate
        for (int r = 0; r < 4; r++) begin
            int cnt;
            start(2'(r), 3'b000, 1'b0, 1'b0);
            noisy = 1'b0;
            put_level(1'b0, 70);
            do @(negedge clk); while (!bclk_en);
            cnt = 0;
            do begin @(negedge clk); cnt++; end while (!bclk_en);
            chk("R1 bclk spacing", cnt, ratio_of(2'(r)));
        end

        // R2 / R3 configuration legality
        @(negedge clk);
        rate_sel = 2'b10; code_sel = 3'b011; #1 chk("R2 reserved 011", int'(cfg_err), 1);
        code_sel = 3'b101; #1 chk("R2 reserved 101", int'(cfg_err), 1);
        code_sel = 3'b111; #1 chk("R2 reserved 111", int'(cfg_err), 1);
        code_sel = 3'b110; #1 chk("R2 dman legal at 16x", int'(cfg_err), 0);
        rate_sel = 2'b00; code_sel = 3'b010; #1 chk("R3 fm at 1x", int'(cfg_err), 1);
        code_sel = 3'b100; #1 chk("R3 manchester at 1x", int'(cfg_err), 1);
        code_sel = 3'b110; #1 chk("R3 dman at 1x", int'(cfg_err), 1);
        code_sel = 3'b001; #1 chk("R3 nrzi at 1x", int'(cfg_err), 0);
        rate_sel = 2'b01; code_sel = 3'b100; #1 chk("R3 manchester at 8x", int'(cfg_err), 0);

        // R4 illegal configuration stays silent
        start(2'b00, 3'b100, 1'b0, 1'b0);
        for (int i = 0; i < 50; i++) put_level(i[0], 2);
        chk("R4 no bclk_en", n_bclk, 0);
        chk("R4 no bit_vld", n_got, 0);
        chk("R4 no cv_err", n_cv, 0);

        // R11 lock delay at 1x
        start(2'b00, 3'b000, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) send_bit(i[1], 1, 3'b000, 1'b0, 0);
        chk("R11 pulses before first valid", n_pre, 8);
        chk("R11 valid count", n_got, n_bclk - 8);

        // R12 violation after lock, FM at 16x
        start(2'b10, 3'b010, 1'b0, 1'b0);
        for (int i = 0; i < PRE_BITS; i++) send_bit(1'b1, 16, 3'b010, 1'b0, 0);
        n_cv = 0;
        put_level(lvl, 8);
        lvl = ~lvl;
        put_level(lvl, 8);
        for (int i = 0; i < 8; i++) send_bit(1'b1, 16, 3'b010, 1'b0, 0);
        chk("R12 violation flagged", int'(n_cv >= 1), 1);

        summary();
        $finish;
    end

endmodule